// File: doc/BRIEF.md
# Link Synchronization Sequencer

This block brings a three-wire handshake link to a known state after reset, before a transaction engine is allowed to use it. The link has two outputs toward an external controller, a session line and a byte-acknowledge line (both active low), and one input from it, a request line (also active low). Bytes move through an external shift register, which reports a shift-complete flag. The sequencer takes the link lines as outputs, sets the shift register to shift in on the external clock and discards any stale byte. It then leaves both outputs negated for a settle time and flushes the shift register again. After that it probes the controller by asserting the acknowledge line alone and checks that the controller answers in the expected order.

The answer comes in four steps: the request line asserts, a shift-complete event arrives, the acknowledge line is released and the request line releases, and a second shift-complete event arrives. Each step has its own timeout window, measured in ticks of a prescaler whose divide ratio comes from the clock frequency. A full answer ends with a one-cycle done pulse. A step that runs out of time ends with a one-cycle error pulse and a code naming that step. The session line is never asserted, and in both cases the link is left with both outputs negated. The transaction engine takes over once either pulse has been seen.

Top module: `lnk_sync_seq`

## Requirements
- R1: After reset the block is idle. `tip_n_o` and `ack_n_o` are 1, `lines_oe_o` and `sr_in_ext_o` are 0, and `sr_rd_o`, `flag_clr_o`, `done_o` and `err_o` are 0.
- R2: A `start_i` seen in idle starts the sequence. In the cycle after the sampling edge (cycle 0) `sr_rd_o` is 1. From cycle 1 on, `lines_oe_o` and `sr_in_ext_o` are 1, and they stay 1 until reset.
- R3: Settle time. In cycles 1 to SETTLE_TICKS*TICK_DIV, `ack_n_o` stays 1 and no strobe is issued. In the next cycle (cycle A-1, where A = 2+SETTLE_TICKS*TICK_DIV) `sr_rd_o` and `flag_clr_o` are both 1.
- R4: The probe. `ack_n_o` is 0 from cycle A until the end of the cycle that clears the first answer flag. `tip_n_o` stays 1 for the whole time.
- R5: The waits run in this fixed order: `req_n_i`=0, then `sr_flag_i`=1, then a cycle with `sr_rd_o` and `flag_clr_o` high while `ack_n_o` is still 0, then `req_n_i`=1 with `ack_n_o` released, then `sr_flag_i`=1, then a final cycle with `sr_rd_o` and `flag_clr_o` high. A wait condition is sampled on every clock, and the sequence moves to the next step in the cycle after the condition is seen.
- R6: An input that the current step does not wait for has no effect. This covers `req_n_i` and `sr_flag_i` during settle, `sr_flag_i` while waiting on the request line, and `req_n_i` while waiting on the flag.
- R7: A wait entered at cycle W0 that has not seen its condition by cycle W0+POLL_LIMIT*TICK_DIV-1 gives `err_o`=1 for exactly cycle W0+POLL_LIMIT*TICK_DIV. `err_step_o` then names the step: 1 for request assert, 2 for the first flag, 3 for request release, 4 for the second flag. A condition seen in the last cycle of the window still counts as success.
- R8: `done_o` is 1 for exactly the one cycle after the final clear cycle. `done_o` and `err_o` are never 1 together, and each start ends in exactly one of them.
- R9: In the done or error cycle, and in idle after it, `ack_n_o` and `tip_n_o` are 1 and no strobe is issued.
- R10: A `start_i` that arrives while the sequence runs is ignored.
- R11: After done or error, a new `start_i` runs the full sequence again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts the sequence when idle |
| req_n_i | input | 1 | Controller request line, active low |
| sr_flag_i | input | 1 | Shift-complete flag level |
| tip_n_o | output | 1 | Session line, active low (held negated) |
| ack_n_o | output | 1 | Byte-acknowledge line, active low |
| lines_oe_o | output | 1 | Drive the session and acknowledge lines as outputs (request line stays an input) |
| sr_in_ext_o | output | 1 | Shift register set to shift in on the external clock |
| sr_rd_o | output | 1 | One-cycle strobe that reads (discards) the shift register |
| flag_clr_o | output | 1 | One-cycle strobe that clears the shift-complete flag |
| done_o | output | 1 | One-cycle pulse on a successful sequence |
| err_o | output | 1 | One-cycle pulse on a timeout |
| err_step_o | output | 3 | Step that timed out, valid while err_o is 1 |

## Verification
The embedded assertions check on every cycle the properties that hold in any state. Done and error never coincide. Each pulse lasts one cycle. Done always follows a flag-clear cycle. An error always comes from a wait step and carries a legal step code. Link setup stays on once it is set. The timer never passes its current limit, and the acknowledge line is negated after the sequence ends. Exact cycle placement needs the bench's scenarios, which sweep every combination of response delays per step (immediate, one cycle, last cycle of the window, never). Those scenarios cover the settle length, the probe window, the order of the steps, stray inputs being ignored, start being ignored while busy, and restart.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_SETTLE,
    ST_CLR0,
    ST_W_REQ_ON,
    ST_W_FLAG1,
    ST_CLR1,
    ST_W_REQ_OFF,
    ST_W_FLAG2,
    ST_CLR2,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  localparam int unsigned STEP_W = 3;

  localparam logic [STEP_W-1:0] STEP_NONE    = 3'd0;
  localparam logic [STEP_W-1:0] STEP_REQ_ON  = 3'd1;
  localparam logic [STEP_W-1:0] STEP_FLAG1   = 3'd2;
  localparam logic [STEP_W-1:0] STEP_REQ_OFF = 3'd3;
  localparam logic [STEP_W-1:0] STEP_FLAG2   = 3'd4;

endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/lss_tick_gen.sv
module lss_tick_gen #(
  parameter int unsigned TICK_DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);

  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == LAST);
    tick_o = at_end;
    if (restart_i || at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R7

  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/lss_step_timer.sv
module lss_step_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expire_o = tick_i && (cnt_q == (limit_i - 1'b1));
    cnt_en   = clear_i || tick_i;
    if (clear_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TMR_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i); // R7

endmodule

// File: rtl/lss_seq_fsm.sv
module lss_seq_fsm
  import lss_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 40,
  parameter int unsigned POLL_LIMIT   = 1000,
  parameter int unsigned CW           = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_n_i,
  input  logic              flag_i,
  input  logic              expire_i,
  output logic              tmr_clr_o,
  output logic [CW-1:0]     limit_o,
  output logic              tip_n_o,
  output logic              ack_n_o,
  output logic              cfg_o,
  output logic              sr_rd_o,
  output logic              flag_clr_o,
  output logic              done_o,
  output logic              err_o,
  output logic [STEP_W-1:0] err_step_o
);

  seq_state_e          state_q, state_d;
  logic                cfg_q, cfg_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                timed;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_INIT;
      ST_INIT:      state_d = ST_SETTLE;
      ST_SETTLE:    if (expire_i) state_d = ST_CLR0;
      ST_CLR0:      state_d = ST_W_REQ_ON;
      ST_W_REQ_ON: begin
        if (!req_n_i) begin
          state_d = ST_W_FLAG1;
        end else if (expire_i) begin
          state_d = ST_ERR;
          step_d  = STEP_REQ_ON;
        end
      end
      ST_W_FLAG1: begin
        if (flag_i) begin
          state_d = ST_CLR1;
        end else if (expire_i) begin
          state_d = ST_ERR;
          step_d  = STEP_FLAG1;
        end
      end
      ST_CLR1:      state_d = ST_W_REQ_OFF;
      ST_W_REQ_OFF: begin
        if (req_n_i) begin
          state_d = ST_W_FLAG2;
        end else if (expire_i) begin
          state_d = ST_ERR;
          step_d  = STEP_REQ_OFF;
        end
      end
      ST_W_FLAG2: begin
        if (flag_i) begin
          state_d = ST_CLR2;
        end else if (expire_i) begin
          state_d = ST_ERR;
          step_d  = STEP_FLAG2;
        end
      end
      ST_CLR2:      state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      ST_ERR:       state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Timer control and link setup
  always_comb begin
    timed = (state_q == ST_SETTLE)    || (state_q == ST_W_REQ_ON) ||
            (state_q == ST_W_FLAG1)   || (state_q == ST_W_REQ_OFF) ||
            (state_q == ST_W_FLAG2);
    tmr_clr_o = !timed || (state_d != state_q);
    limit_o   = (state_q == ST_SETTLE) ? CW'(SETTLE_TICKS) : CW'(POLL_LIMIT);
    cfg_d     = cfg_q || (state_q == ST_INIT);
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= 1'b0;
      step_q  <= STEP_NONE;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      step_q  <= step_d;
    end
  end

  // Moore outputs
  always_comb begin
    tip_n_o    = 1'b1;
    ack_n_o    = !((state_q == ST_W_REQ_ON) || (state_q == ST_W_FLAG1) ||
                   (state_q == ST_CLR1));
    cfg_o      = cfg_q;
    sr_rd_o    = (state_q == ST_INIT) || (state_q == ST_CLR0) ||
                 (state_q == ST_CLR1) || (state_q == ST_CLR2);
    flag_clr_o = (state_q == ST_CLR0) || (state_q == ST_CLR1) ||
                 (state_q == ST_CLR2);
    done_o     = (state_q == ST_DONE);
    err_o      = (state_q == ST_ERR);
    err_step_o = step_q;
  end

  AST_CFG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q |=> cfg_q); // R2

  AST_ERR_STEP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((err_step_o >= STEP_REQ_ON) && (err_step_o <= STEP_FLAG2))); // R7

  AST_ERR_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (($past(state_q) == ST_W_REQ_ON)  || ($past(state_q) == ST_W_FLAG1) ||
               ($past(state_q) == ST_W_REQ_OFF) || ($past(state_q) == ST_W_FLAG2))); // R7

  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(flag_clr_o)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R7

endmodule

// File: rtl/lnk_sync_seq.sv
module lnk_sync_seq
  import lss_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 250_000,
  parameter int unsigned TICK_US    = 100,
  parameter int unsigned SETTLE_US  = 4000,
  parameter int unsigned POLL_LIMIT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_n_i,
  input  logic              sr_flag_i,
  output logic              tip_n_o,
  output logic              ack_n_o,
  output logic              lines_oe_o,
  output logic              sr_in_ext_o,
  output logic              sr_rd_o,
  output logic              flag_clr_o,
  output logic              done_o,
  output logic              err_o,
  output logic [STEP_W-1:0] err_step_o
);

  localparam int unsigned TICK_DIV     = (CLK_KHZ * TICK_US) / 1000;
  localparam int unsigned SETTLE_TICKS = SETTLE_US / TICK_US;
  localparam int unsigned MAX_LIMIT    = (SETTLE_TICKS > POLL_LIMIT) ? SETTLE_TICKS : POLL_LIMIT;
  localparam int unsigned CW           = $clog2(MAX_LIMIT + 1);

  logic          rst_n;
  logic          tmr_clr;
  logic          tick;
  logic          expire;
  logic [CW-1:0] limit;
  logic          cfg;

  lss_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  lss_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) u_tick_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .restart_i (tmr_clr),
    .tick_o    (tick)
  );

  lss_step_timer #(
    .CW (CW)
  ) u_step_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clear_i  (tmr_clr),
    .tick_i   (tick),
    .limit_i  (limit),
    .expire_o (expire)
  );

  lss_seq_fsm #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .POLL_LIMIT   (POLL_LIMIT),
    .CW           (CW)
  ) u_seq_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .req_n_i    (req_n_i),
    .flag_i     (sr_flag_i),
    .expire_i   (expire),
    .tmr_clr_o  (tmr_clr),
    .limit_o    (limit),
    .tip_n_o    (tip_n_o),
    .ack_n_o    (ack_n_o),
    .cfg_o      (cfg),
    .sr_rd_o    (sr_rd_o),
    .flag_clr_o (flag_clr_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_step_o (err_step_o)
  );

  assign lines_oe_o  = cfg;
  assign sr_in_ext_o = cfg;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(done_o && err_o)); // R8

  AST_LINK_QUIET_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o || err_o) |=> (ack_n_o && !sr_rd_o && !flag_clr_o)); // R9

  AST_ACK_NEEDS_SETUP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ack_n_o |-> lines_oe_o); // R4

endmodule

// File: tb/lnk_sync_seq_bench.sv
module lnk_sync_seq_bench;

  localparam int TD   = 4;            // clock cycles per tick
  localparam int ST   = 3;            // settle ticks
  localparam int PL   = 5;            // poll limit in ticks
  localparam int W    = PL * TD;      // wait window in cycles
  localparam int A    = 2 + ST * TD;  // first wait cycle
  localparam int BIG  = 1 << 28;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic       req_n_i;
  logic       sr_flag_i;
  logic       tip_n_o, ack_n_o, lines_oe_o, sr_in_ext_o;
  logic       sr_rd_o, flag_clr_o, done_o, err_o;
  logic [2:0] err_step_o;

  int nchk = 0;
  int nerr = 0;
  bit cfg_ever = 1'b0;
  bit finished = 1'b0;

  lnk_sync_seq #(
    .CLK_KHZ    (40),
    .TICK_US    (100),
    .SETTLE_US  (300),
    .POLL_LIMIT (PL)
  ) u_lnk_sync_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .req_n_i     (req_n_i),
    .sr_flag_i   (sr_flag_i),
    .tip_n_o     (tip_n_o),
    .ack_n_o     (ack_n_o),
    .lines_oe_o  (lines_oe_o),
    .sr_in_ext_o (sr_in_ext_o),
    .sr_rd_o     (sr_rd_o),
    .flag_clr_o  (flag_clr_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_step_o  (err_step_o)
  );

  always #2 clk_i = ~clk_i;   // 250 MHz

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Runs one sequence; d1..d4 are response delays (>= W means never).
  task automatic run_case(input int d1, input int d2, input int d3, input int d4,
                          input bit stale, input bit extra, input bit first);
    int b, cc, dd, e, f, errc, step, endc, ack_end;
    b = BIG; cc = BIG; dd = BIG; e = BIG; f = BIG; errc = -1; step = 0;
    if (d1 >= W) begin errc = A + W; step = 1; end
    else begin
      b = A + d1 + 1;
      if (d2 >= W) begin errc = b + W; step = 2; end
      else begin
        cc = b + d2 + 1; dd = cc + 1;
        if (d3 >= W) begin errc = dd + W; step = 3; end
        else begin
          e = dd + d3 + 1;
          if (d4 >= W) begin errc = e + W; step = 4; end
          else f = e + d4 + 1;
        end
      end
    end
    endc    = (errc >= 0) ? errc : f + 1;
    ack_end = (cc < endc - 1) ? cc : endc - 1;

    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c <= endc + 2; c++) begin
      // outputs of cycle c
      chk("R4", "tip_n_o", tip_n_o, 1);
      if (c <= endc) begin
        chk("R4", "ack_n_o", ack_n_o, (c >= A && c <= ack_end) ? 0 : 1);
        chk((c == 0) ? (first ? "R2" : "R11") : "R3", "sr_rd_o", sr_rd_o,
            (c == 0 || c == A - 1 || c == cc || c == f) ? 1 : 0);
        chk((c == cc || c == f) ? "R5" : "R3", "flag_clr_o", flag_clr_o,
            (c == A - 1 || c == cc || c == f) ? 1 : 0);
        chk("R2", "lines_oe_o", lines_oe_o, (c >= 1 || cfg_ever) ? 1 : 0);
        chk("R2", "sr_in_ext_o", sr_in_ext_o, (c >= 1 || cfg_ever) ? 1 : 0);
        chk("R8", "done_o", done_o, (errc < 0 && c == f + 1) ? 1 : 0);
        chk("R7", "err_o", err_o, (errc >= 0 && c == errc) ? 1 : 0);
        if (errc >= 0 && c == errc) chk("R7", "err_step_o", err_step_o, step);
        if (c == endc)
          chk(stale ? "R6" : (extra ? "R10" : "R5"), "sequence end",
              int'(done_o || err_o), 1);
      end else begin
        chk("R9", "ack_n_o idle", ack_n_o, 1);
        chk("R9", "sr_rd_o idle", sr_rd_o, 0);
        chk("R9", "flag_clr_o idle", flag_clr_o, 0);
        chk("R8", "done_o idle", done_o, 0);
        chk("R8", "err_o idle", err_o, 0);
      end
      // inputs for cycle c
      req_n_i = !(((d1 < W) && (c >= A + d1) && (c < dd + d3) && (c < endc)) ||
                  (stale && c >= 1 && c <= A - 2));
      sr_flag_i = ((d2 < W) && (c >= b + d2) && (c <= cc)) ||
                  ((d4 < W) && (c >= e + d4) && (c <= f)) ||
                  (stale && c >= 1 && c <= A - 1);
      start_i = extra && (c == 5 || c == A + 1);
      @(negedge clk_i);
    end
    start_i = 1'b0; req_n_i = 1'b1; sr_flag_i = 1'b0;
    cfg_ever = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    int vals[4];
    bit first;
    vals[0] = 0; vals[1] = 1; vals[2] = W - 1; vals[3] = W;
    rst_ni = 1'b0; start_i = 1'b0; req_n_i = 1'b1; sr_flag_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    // R1: reset state
    chk("R1", "tip_n_o", tip_n_o, 1);
    chk("R1", "ack_n_o", ack_n_o, 1);
    chk("R1", "lines_oe_o", lines_oe_o, 0);
    chk("R1", "sr_in_ext_o", sr_in_ext_o, 0);
    chk("R1", "sr_rd_o", sr_rd_o, 0);
    chk("R1", "flag_clr_o", flag_clr_o, 0);
    chk("R1", "done_o", done_o, 0);
    chk("R1", "err_o", err_o, 0);
    first = 1'b1;
    for (int i1 = 0; i1 < 4; i1++)
      for (int i2 = 0; i2 < 4; i2++)
        for (int i3 = 0; i3 < 4; i3++)
          for (int i4 = 0; i4 < 4; i4++) begin
            run_case(vals[i1], vals[i2], vals[i3], vals[i4],
                     (i3 == 1), (i4 == 2), first);
            first = 1'b0;
          end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule